// File: doc/BRIEF.md
# Set/Reset Compare PWM Timer

This block is one 16-bit timer channel that makes a pulse-width-modulated waveform from two compare registers. When the counter reaches the value in the "rise" register, the output goes high. When it reaches the value in the "fall" register, the output goes low. Either match can also restart the counter, so the same pair of registers sets both the period and the duty cycle. The duty cycle can be anywhere from 0% to 100%.

Software programs the channel through a small register port. One control register picks the count clock: the system clock divided by 1, 2, 4 or 8, or an external clock input. For the external clock it also picks which edge is counted. The same register picks what clears the counter, enables PWM mode and holds the run bit. The counter and both compare registers can be read and written on the same port.

Top module: `pwm_cmp_timer`

## Requirements
- R1: In PWM mode (ctrl[7]=1), a count cycle where the counter equals the rise register and not the fall register drives `pwm_out` to 1 at the next clock edge.
- R2: In PWM mode, a count cycle where the counter equals the fall register and not the rise register drives `pwm_out` to 0 at the next clock edge.
- R3: Clear select ctrl[6:5] works as follows: 01 clears on a rise match, 10 clears on a fall match, and 00 or 11 never clears. On a count cycle with a selected match, the counter loads 0, so the period is the compare value plus one count. Clearing on the fall match with rise > fall gives 0% duty. Clearing on the rise match with fall > rise gives 100% duty.
- R4: When both registers hold the same value, a match on that value leaves `pwm_out` unchanged, whether it is low or high.
- R5: Clock select ctrl[2:0] values 0 to 3 count every 1, 2, 4 or 8 system clocks. The divider restarts from zero while the channel is stopped, so after the run bit is set the first count with divide-by-4 comes on the 4th clock. Values 4 to 7 count the external clock.
- R6: Edge select ctrl[4:3] works as follows: 00 counts rising edges of `ext_clk`, 01 counts falling edges, and 1x counts both. The input passes through a two-flop synchroniser first.
- R7: The counter changes only while the run bit ctrl[8] is 1, apart from bus writes. When the bit is 0, the count holds.
- R8: When no clear source is selected, the counter wraps from 0xFFFF to 0x0000.
- R9: After reset, ctrl reads 0, the counter reads 0x0000, both compare registers read 0xFFFF, and `pwm_out` is 0.
- R10: When PWM mode is off, compare matches do not move `pwm_out`; it holds its level.
- R11: Address 0 is ctrl (bits 8:0), 1 is the counter, 2 is the rise register and 3 is the fall register. All are readable at `rdata` combinationally. A counter write takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| ext_clk | input | 1 | External count clock, asynchronous |
| pwm_out | output | 1 | PWM waveform |

## Verification
Two functions can fall in the same count cycle: the rise-register match that sets the output, and the counter clear selected on that same match. The clear-on-rise vectors force this to happen in every period. The bench judges it by counting high samples over exactly two periods and comparing the count with the value the compare settings predict. A second overlap is the two matches landing on one value at the same time. Equal compare values provoke it, once with the output low and once with it high, and the check is that the level never moves.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_RISE  = 2'b01,
    CLR_FALL  = 2'b10,
    CLR_NONE2 = 2'b11
  } clr_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_BTH2 = 2'b11
  } edge_sel_e;

  // Prescaler mask: count fires when (presc & mask) == mask, giving divide by 2**sel.
  function automatic logic [2:0] presc_mask(input logic [1:0] sel);
    logic [2:0] m;
    m = 3'((4'd1 << sel) - 4'd1);
    return m;
  endfunction

  // True when the selected edge kind is seen between two synchronised samples.
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    logic up, dn;
    up = cur & ~prev;
    dn = prev & ~cur;
    case (sel)
      EDGE_RISE: return up;
      EDGE_FALL: return dn;
      default:   return up | dn;
    endcase
  endfunction

  // Next output level from the two match events.
  function automatic logic pwm_next(input logic en, input logic m_rise,
                                    input logic m_fall, input logic cur);
    if (!en)                 return cur;
    if (m_rise && !m_fall)   return 1'b1;
    if (m_fall && !m_rise)   return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import pwmt_pkg::*;
#(
  parameter int PW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] src_sel,
  input  logic [1:0] edge_sel,
  input  logic       ext_in,
  output logic       tick
);
  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic          prev_q;
  logic [PW-1:0] presc_q;
  logic [PW-1:0] mask;
  logic          int_tick, ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      presc_q <= '0;
    end else begin
      sync_q  <= {sync_q[SW-2:0], ext_in};
      prev_q  <= sync_q[SW-1];
      presc_q <= run ? presc_q + 1'b1 : '0;
    end
  end

  assign mask     = PW'(presc_mask(src_sel[1:0]));
  assign int_tick = run && ((presc_q & mask) == mask);
  assign ext_tick = run && edge_hit(edge_sel, prev_q, sync_q[SW-1]);
  assign tick     = src_sel[2] ? ext_tick : int_tick;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cmp_rise,
  input  logic [W-1:0] cmp_fall,
  input  logic [1:0]   clr_sel,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic         match_rise,
  output logic         match_fall,
  output logic         clr_hit
);
  logic [W-1:0] cnt_q;

  assign match_rise = tick && (cnt_q == cmp_rise);
  assign match_fall = tick && (cnt_q == cmp_fall);
  assign clr_hit    = ((clr_sel == CLR_RISE) && match_rise) ||
                      ((clr_sel == CLR_FALL) && match_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wr_val;
    else if (clr_hit)  cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_pwm_out.sv
module tmr_pwm_out
  import pwmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_en,
  input  logic match_rise,
  input  logic match_fall,
  output logic level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= pwm_next(pwm_en, match_rise, match_fall, level);
  end
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwmt_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 2,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          ext_clk,
  output logic          pwm_out
);
  localparam int CTRL_W = 9;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_RISE = AW'(2);
  localparam logic [AW-1:0] A_FALL = AW'(3);

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      rise_q, fall_q;
  logic [W-1:0]      cnt;
  logic              tick, match_rise, match_fall, clr_hit;
  logic              run, pwm_en, wr_cnt;
  logic [2:0]        src_sel;
  logic [1:0]        edge_sel, clr_sel;

  assign src_sel  = ctrl_q[2:0];
  assign edge_sel = ctrl_q[4:3];
  assign clr_sel  = ctrl_q[6:5];
  assign pwm_en   = ctrl_q[7];
  assign run      = ctrl_q[8];
  assign wr_cnt   = wr_en && (addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rise_q <= '1;
      fall_q <= '1;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q <= wdata[CTRL_W-1:0];
        A_RISE:  rise_q <= wdata;
        A_FALL:  fall_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = W'(ctrl_q);
      A_CNT:   rdata = cnt;
      A_RISE:  rdata = rise_q;
      default: rdata = fall_q;
    endcase
  end

  tmr_tick_gen #(.PW(PW), .SYNC_STAGES(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .edge_sel(edge_sel), .ext_in(ext_clk), .tick(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_rise(rise_q), .cmp_fall(fall_q),
    .clr_sel(clr_sel), .wr_cnt(wr_cnt), .wr_val(wdata), .cnt(cnt),
    .match_rise(match_rise), .match_fall(match_fall), .clr_hit(clr_hit)
  );

  tmr_pwm_out u_out (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .match_rise(match_rise),
    .match_fall(match_fall), .level(pwm_out)
  );

endmodule

// File: rtl/pwm_cmp_timer_chk.sv
module pwm_cmp_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         match_rise,
  input logic         match_fall,
  input logic         clr_hit,
  input logic         pwm_en,
  input logic         run,
  input logic         wr_cnt,
  input logic [W-1:0] cnt,
  input logic         pwm_out
);
  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && match_rise && !match_fall) |=> pwm_out);

  a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && match_fall && !match_rise) |=> !pwm_out);

  a_r4_equal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (match_rise && match_fall) |=> $stable(pwm_out));

  a_r10_mode_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> $stable(pwm_out));

  a_r3_clear_loads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !wr_cnt) |=> (cnt == '0));

  a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));

  a_r8_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_hit && !wr_cnt && (cnt == '1)) |=> (cnt == '0));
endmodule

bind pwm_cmp_timer pwm_cmp_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .match_rise(match_rise),
  .match_fall(match_fall), .clr_hit(clr_hit), .pwm_en(pwm_en), .run(run),
  .wr_cnt(wr_cnt), .cnt(cnt), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_cmp_timer.sv
`timescale 1ns/1ps
module tb_pwm_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        ext_clk = 1'b0;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;

  localparam int RUN = 256, PWM = 128;
  // columns: rise, fall, clear select, clock select, window cycles, expected high samples
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{2, 9, 2, 0, 20, 14},   // R2 R1 clear on fall, 70%
    '{0, 4, 2, 0, 10, 8},    // R1 rise at zero
    '{5, 3, 1, 0, 12, 8},    // R3 clear on rise coincides with set
    '{3, 7, 1, 0, 8, 8},     // R3 100%
    '{1, 3, 2, 1, 16, 8},    // R5 divide by 2
    '{9, 5, 2, 0, 12, 0}     // R3 0%
  };

  pwm_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk(ext_clk), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = 2'(a); wdata = 16'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 2'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic setup(input int r, input int f, input int ctrl);
    wr(0, 0); wr(1, 0); wr(2, r); wr(3, f); wr(0, ctrl);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (pwm_out) h++;
    end
  endtask

  task automatic ext_test(input int edge_sel, input int exp, input string req);
    int v;
    wr(0, 0); wr(1, 0);
    wr(0, RUN | 4 | (edge_sel << 3));
    for (int p = 0; p < 3; p++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(0, 0);
    rd(1, v);
    check(req, v, exp);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(0, v); check("R9 ctrl", v, 0);
    rd(1, v); check("R9 counter", v, 0);
    rd(2, v); check("R9 rise", v, 16'hFFFF);
    rd(3, v); check("R9 fall", v, 16'hFFFF);
    check("R9 pwm_out", int'(pwm_out), 0);

    // vector table: duty over exactly two periods
    for (int k = 0; k < NV; k++) begin
      setup(VEC[k][0], VEC[k][1], RUN | PWM | (VEC[k][2] << 5) | VEC[k][3]);
      repeat (VEC[k][4]) @(negedge clk);
      count_high(VEC[k][4], h);
      check($sformatf("R1 R2 R3 vector %0d high count", k), h, VEC[k][5]);
    end

    // R4 equal values, output low
    setup(3, 3, RUN | PWM | (2 << 5));
    count_high(20, h);
    check("R4 equal keeps low", h, 0);
    // drive high with 100% set, then equal values
    setup(3, 7, RUN | PWM | (1 << 5));
    repeat (10) @(negedge clk);
    setup(3, 3, RUN | PWM | (2 << 5));
    count_high(20, h);
    check("R4 equal keeps high", h, 20);
    // R10 mode off: output held high despite matches
    setup(2, 9, RUN | (2 << 5));
    count_high(30, h);
    check("R10 mode off holds", h, 30);

    // R11 readback of compare register
    rd(2, v); check("R11 rise readback", v, 2);

    // R8 wrap with no clear
    wr(0, 0); wr(1, 16'hFFFE); wr(0, RUN);
    repeat (2) @(negedge clk);
    wr(0, 0);
    rd(1, v); check("R8 wrap", v, 1);
    // R7 stopped counter holds
    repeat (10) @(negedge clk);
    rd(1, v); check("R7 hold", v, 1);

    // R5 divide by 4: 8 run edges, 2 counts
    wr(0, 0); wr(1, 0); wr(0, RUN | 2);
    repeat (7) @(negedge clk);
    wr(0, 0);
    rd(1, v); check("R5 div4 count", v, 2);

    // R6 external edges
    ext_test(0, 3, "R6 rising");
    ext_test(1, 3, "R6 falling");
    ext_test(2, 6, "R6 both");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule